// File: doc/BRIEF.md
# Incremental Line Address Stepper

This block draws a straight line by walking framebuffer addresses directly instead of x/y coordinates. Software fills three working quantities: a distance, a pixel address and a decision error. For each of them it loads a starting value, a diagonal increment used when both axes advance, and a major-axis increment used when only the major axis advances. It also loads a step count and a control word.

A start pulse begins a line. On every step the sign of the current error picks one set of increments, and all three are added at once. Each resulting address is offered on a valid/ready output, one per cycle when the consumer keeps ready high. The line ends after the programmed number of steps. A control bit decides whether the starting address is also emitted. A busy flag covers the whole line. Pixel data, raster operations, masking and the memory itself are handled elsewhere.

Top module: `line_addr_stepper`

## Requirements
- R1: After reset, `busy` and `pix_valid` are 0.
- R2: A `go` pulse while idle, with a nonzero step count or with draw-first set, makes `busy` and `pix_valid` 1 on the next cycle.
- R3: With draw-first set (bit 4 of the control word), the first address offered is the initial address, together with the initial distance and error.
- R4: With draw-first clear, the starting point is not offered, and the first address offered is the one after a single step from the initial values.
- R5: In each step, if the error is negative (its top bit is 1), the major-only increments are added to distance, address and error. Otherwise the diagonal increments are added.
- R6: A line with step count N offers exactly N addresses when draw-first is clear and N+1 when it is set. A `go` with N = 0 and draw-first clear is ignored, so `busy` stays 0.
- R7: While `pix_valid` is 1 and `pix_ready` is 0, `pix_addr`, `cur_dist` and `cur_err` hold their values.
- R8: `busy` falls on the cycle after the last address is accepted, and stays 1 until then.
- R9: All quantities are W bits wide, and the additions wrap modulo 2^W.
- R10: A write to any diagonal or major-only increment while `busy` is 1 is ignored, and it stays ignored for later lines.
- R11: A `go` while `busy` is 1 is ignored. This includes the cycle in which the last address is accepted.
- R12: Write select codes: distance 0/1/2, address 3/4/5, error 6/7/8. Within each group the order is initial, diagonal, major-only. Code 9 is the step count and code 10 is the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | W | Register write data |
| go | input | 1 | Start a line |
| pix_ready | input | 1 | Consumer accepts the offered address |
| pix_valid | output | 1 | An address is offered |
| pix_addr | output | W | Offered pixel address |
| busy | output | 1 | A line is in progress |
| cur_dist | output | W | Distance belonging to the offered address |
| cur_err | output | W | Error belonging to the offered address |

## Verification
Two events can land in the same cycle: acceptance of the final address, and a new start pulse together with an increment write. Because busy is still high on that edge, both the start and the write must be ignored. The bench raises `go` and writes a new diagonal address increment exactly on the final handshake. It then expects busy to be low and no new line to begin. It also expects the next line to follow the old increments. The same collision is provoked in the middle of a line, and every line is replayed under several stall patterns against arithmetic computed in the bench.

// File: rtl/lstep_pkg.sv
package lstep_pkg;

    localparam int LANES     = 3;
    localparam int LANE_DIST = 0;
    localparam int LANE_ADDR = 1;
    localparam int LANE_ERR  = 2;

    localparam int KIND_INIT = 0;
    localparam int KIND_DIAG = 1;
    localparam int KIND_MAJ  = 2;
    localparam int KINDS     = 3;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIST_INIT = 4'd0,
        SEL_DIST_DIAG = 4'd1,
        SEL_DIST_MAJ  = 4'd2,
        SEL_ADDR_INIT = 4'd3,
        SEL_ADDR_DIAG = 4'd4,
        SEL_ADDR_MAJ  = 4'd5,
        SEL_ERR_INIT  = 4'd6,
        SEL_ERR_DIAG  = 4'd7,
        SEL_ERR_MAJ   = 4'd8,
        SEL_STOP      = 4'd9,
        SEL_CTRL      = 4'd10
    } lstep_sel_e;

    localparam int CTRL_DRAW_FIRST_BIT = 4;

endpackage

// File: rtl/lstep_regs.sv
module lstep_regs import lstep_pkg::*; #(
    parameter int W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [W-1:0]                wr_data,
    input  logic                        busy_i,
    output logic [LANES-1:0][W-1:0]     init_o,
    output logic [LANES-1:0][W-1:0]     diag_o,
    output logic [LANES-1:0][W-1:0]     maj_o,
    output logic [W-1:0]                stop_o,
    output logic                        draw_first_o
);

    typedef struct packed {
        logic [LANES-1:0][W-1:0] init;
        logic [LANES-1:0][W-1:0] diag;
        logic [LANES-1:0][W-1:0] maj;
        logic [W-1:0]            stop;
        logic                    draw_first;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_sel == SEL_W'(KINDS*l + KIND_INIT))
                    r_d.init[l] = wr_data;
                // increments are frozen for the duration of a line
                if (!busy_i && wr_sel == SEL_W'(KINDS*l + KIND_DIAG))
                    r_d.diag[l] = wr_data;
                if (!busy_i && wr_sel == SEL_W'(KINDS*l + KIND_MAJ))
                    r_d.maj[l] = wr_data;
            end
            if (wr_sel == SEL_STOP)
                r_d.stop = wr_data;
            if (wr_sel == SEL_CTRL)
                r_d.draw_first = wr_data[CTRL_DRAW_FIRST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign init_o       = r_q.init;
    assign diag_o       = r_q.diag;
    assign maj_o        = r_q.maj;
    assign stop_o       = r_q.stop;
    assign draw_first_o = r_q.draw_first;

    // R10: increment registers do not move under a running line
    assert_inc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en && (wr_sel inside {SEL_DIST_DIAG, SEL_DIST_MAJ, SEL_ADDR_DIAG,
                                            SEL_ADDR_MAJ, SEL_ERR_DIAG, SEL_ERR_MAJ}))
        |=> ($stable(diag_o) && $stable(maj_o)));

endmodule

// File: rtl/lstep_adder.sv
module lstep_adder import lstep_pkg::*; #(
    parameter int W = 32
) (
    input  logic [LANES-1:0][W-1:0] base_i,
    input  logic [LANES-1:0][W-1:0] diag_i,
    input  logic [LANES-1:0][W-1:0] maj_i,
    output logic                    take_major_o,
    output logic [LANES-1:0][W-1:0] next_o
);

    // negative error selects the major-only increments
    assign take_major_o = base_i[LANE_ERR][W-1];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign next_o[l] = base_i[l] + (take_major_o ? maj_i[l] : diag_i[l]);
    end

endmodule

// File: rtl/lstep_seq.sv
module lstep_seq import lstep_pkg::*; #(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_i,
    input  logic                    ready_i,
    input  logic                    draw_first_i,
    input  logic [W-1:0]            stop_i,
    input  logic [LANES-1:0][W-1:0] init_i,
    input  logic [LANES-1:0][W-1:0] stepped_i,
    output logic                    busy_o,
    output logic [LANES-1:0][W-1:0] work_o
);

    typedef struct packed {
        logic                    busy;
        logic [W-1:0]            rem;
        logic [LANES-1:0][W-1:0] work;
    } seq_t;

    seq_t s_d, s_q;
    logic start_ok;

    assign start_ok = go_i && (draw_first_i || (stop_i != '0));

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start_ok) begin
                s_d.busy = 1'b1;
                if (draw_first_i) begin
                    s_d.work = init_i;
                    s_d.rem  = stop_i;
                end else begin
                    // stepped_i is computed from init_i while idle
                    s_d.work = stepped_i;
                    s_d.rem  = stop_i - 1'b1;
                end
            end
        end else if (ready_i) begin
            if (s_q.rem == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.work = stepped_i;
                s_d.rem  = s_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign work_o = s_q.work;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_ok) |=> busy_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ready_i) |=> (busy_o && $stable(work_o)));

    assert_drop_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(ready_i));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && go_i && ready_i && (s_q.rem == '0)) |=> !busy_o);

endmodule

// File: rtl/line_addr_stepper.sv
module line_addr_stepper import lstep_pkg::*; #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             go,
    input  logic             pix_ready,
    output logic             pix_valid,
    output logic [W-1:0]     pix_addr,
    output logic             busy,
    output logic [W-1:0]     cur_dist,
    output logic [W-1:0]     cur_err
);

    logic [LANES-1:0][W-1:0] init_v, diag_v, maj_v, work_v, base_v, stepped_v;
    logic [W-1:0]            stop_v;
    logic                    draw_first_v;
    logic                    busy_v;
    logic                    take_major_v;

    lstep_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .busy_i       (busy_v),
        .init_o       (init_v),
        .diag_o       (diag_v),
        .maj_o        (maj_v),
        .stop_o       (stop_v),
        .draw_first_o (draw_first_v)
    );

    // one adder set serves both the pre-step at start and the running steps
    assign base_v = busy_v ? work_v : init_v;

    lstep_adder #(.W(W)) u_adder (
        .base_i       (base_v),
        .diag_i       (diag_v),
        .maj_i        (maj_v),
        .take_major_o (take_major_v),
        .next_o       (stepped_v)
    );

    lstep_seq #(.W(W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .ready_i      (pix_ready),
        .draw_first_i (draw_first_v),
        .stop_i       (stop_v),
        .init_i       (init_v),
        .stepped_i    (stepped_v),
        .busy_o       (busy_v),
        .work_o       (work_v)
    );

    assign busy      = busy_v;
    assign pix_valid = busy_v;
    assign pix_addr  = work_v[LANE_ADDR];
    assign cur_dist  = work_v[LANE_DIST];
    assign cur_err   = work_v[LANE_ERR];

    // R5: a negative error steps along the major axis
    assert_major_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && take_major_v && !$isunknown(maj_v)) |=> 
        (!pix_valid || (pix_addr == $past(pix_addr) + $past(maj_v[LANE_ADDR]))));

endmodule

// File: tb/tb_line_addr_stepper.sv
module tb_line_addr_stepper;
    import lstep_pkg::*;

    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [W-1:0]     wr_data;
    logic             go;
    logic             pix_ready;
    logic             pix_valid;
    logic [W-1:0]     pix_addr;
    logic             busy;
    logic [W-1:0]     cur_dist;
    logic [W-1:0]     cur_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_addr_stepper #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .go(go), .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_addr(pix_addr),
        .busy(busy), .cur_dist(cur_dist), .cur_err(cur_err)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [W-1:0] sh_init [LANES];
    logic [W-1:0] sh_diag [LANES];
    logic [W-1:0] sh_maj  [LANES];
    logic [W-1:0] sh_stop;
    bit           sh_df;
    logic [W-1:0] m [LANES];

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic mstep();
        bit neg = m[LANE_ERR][W-1];
        for (int l = 0; l < LANES; l++)
            m[l] = m[l] + (neg ? sh_maj[l] : sh_diag[l]);
    endtask

    // R12: select code = 3*lane + kind, 9 step count, 10 control
    task automatic set_reg(input logic [SEL_W-1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (s < 4'd9) begin
            case (int'(s) % 3)
                KIND_INIT: sh_init[int'(s)/3] = d;
                KIND_DIAG: sh_diag[int'(s)/3] = d;
                default:   sh_maj[int'(s)/3]  = d;
            endcase
        end else if (s == SEL_STOP) sh_stop = d;
        else if (s == SEL_CTRL) sh_df = d[CTRL_DRAW_FIRST_BIT];
    endtask

    task automatic load_cfg(input logic [W-1:0] i0, i1, i2, d0, d1, d2, j0, j1, j2);
        set_reg(SEL_DIST_INIT, i0); set_reg(SEL_ADDR_INIT, i1); set_reg(SEL_ERR_INIT, i2);
        set_reg(SEL_DIST_DIAG, d0); set_reg(SEL_ADDR_DIAG, d1); set_reg(SEL_ERR_DIAG, d2);
        set_reg(SEL_DIST_MAJ,  j0); set_reg(SEL_ADDR_MAJ,  j1); set_reg(SEL_ERR_MAJ,  j2);
    endtask

    // mode 0: plain; 1: go + increment write on second accept; 2: same on last accept
    task automatic run_line(input logic [7:0] pat, input int mode, input string tag);
        int  exp_n, beats, c;
        bit  stalled, acc, last;
        logic [W-1:0] sa, sd, se;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (sh_stop == '0 && !sh_df) begin
            chk("R6 zero-length go ignored", {31'd0, busy}, 32'd0);
            return;
        end
        chk("R2 busy after go", {31'd0, pix_valid}, 32'd1);
        for (int l = 0; l < LANES; l++) m[l] = sh_init[l];
        if (!sh_df) mstep();
        exp_n = int'(sh_stop) + int'(sh_df);
        beats = 0; c = 0; stalled = 0;
        while (beats < exp_n && c < 2000) begin
            if (stalled) begin
                chk("R7 addr held", pix_addr, sa);
                chk("R7 dist held", cur_dist, sd);
                chk("R7 err held",  cur_err,  se);
            end
            if (!pix_valid) begin
                chk("R6/R8 line ended early", {31'd0, pix_valid}, 32'd1);
                break;
            end
            acc  = !pat[c % 8];
            last = acc && (beats == exp_n - 1);
            pix_ready = acc;
            if ((mode == 1 && acc && beats == 1) || (mode == 2 && last)) begin
                go = 1'b1;
                wr_en = 1'b1; wr_sel = SEL_ADDR_DIAG; wr_data = 32'h5555_5555;
            end
            if (acc) begin
                if (beats == 0)
                    chk(sh_df ? "R3 first addr" : "R4 first addr", pix_addr, m[LANE_ADDR]);
                else
                    chk({tag, " addr"}, pix_addr, m[LANE_ADDR]);
                chk({tag, " dist"}, cur_dist, m[LANE_DIST]);
                chk({tag, " err"},  cur_err,  m[LANE_ERR]);
                beats++;
                if (beats < exp_n) mstep();
            end
            stalled = !acc; sa = pix_addr; sd = cur_dist; se = cur_err;
            c++;
            @(negedge clk);
            go = 1'b0; wr_en = 1'b0;
        end
        pix_ready = 1'b0;
        chk("R8 busy low after last accept", {31'd0, busy}, 32'd0);
        if (mode == 2) begin
            @(negedge clk);
            chk("R11 go on last accept ignored", {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [3];
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'h81;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; go = 1'b0; pix_ready = 1'b0;
        for (int l = 0; l < LANES; l++) begin sh_init[l] = '0; sh_diag[l] = '0; sh_maj[l] = '0; end
        sh_stop = '0; sh_df = 0;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset",  {31'd0, busy},      32'd0);
        chk("R1 valid at reset", {31'd0, pix_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {31'd0, busy}, 32'd0);

        // mixed diagonal/major walk
        load_cfg(32'd0, 32'h0000_1000, 32'hFFFF_FFFD,
                 32'd1, 32'h0000_0401, 32'hFFFF_FFF8,
                 32'd1, 32'h0000_0001, 32'd5);
        for (int n = 0; n <= 6; n++)
            for (int df = 0; df < 2; df++)
                for (int p = 0; p < 3; p++) begin
                    set_reg(SEL_STOP, n);
                    set_reg(SEL_CTRL, df ? 32'h10 : 32'h0);
                    run_line(pats[p], 0, "R5");
                end

        // decrementing addresses that wrap through zero and the top
        load_cfg(32'hFFFF_FFFE, 32'h0000_0002, 32'h7FFF_FFFE,
                 32'd1, 32'hFFFF_FBFF, 32'h8000_0003,
                 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFF0);
        for (int n = 1; n <= 5; n++)
            for (int df = 0; df < 2; df++) begin
                set_reg(SEL_STOP, n);
                set_reg(SEL_CTRL, df ? 32'h10 : 32'h0);
                run_line(pats[n % 3], 0, "R9");
            end

        // collisions: go and increment writes while busy
        load_cfg(32'd0, 32'h0000_2000, 32'hFFFF_FFFF,
                 32'd1, 32'h0000_0201, 32'hFFFF_FFFA,
                 32'd1, 32'h0000_0001, 32'd3);
        set_reg(SEL_STOP, 5);
        set_reg(SEL_CTRL, 32'h0);
        run_line(8'h00, 1, "R10 write mid-line");
        run_line(8'h24, 0, "R10 old increment kept");
        run_line(8'h42, 2, "R11 go on last beat");
        run_line(8'h00, 0, "R10 after last-beat write");
        set_reg(SEL_CTRL, 32'h10);
        run_line(8'h18, 1, "R11 go mid-line");
        set_reg(SEL_STOP, 0);
        run_line(8'h00, 0, "R6 single point");
        set_reg(SEL_CTRL, 32'h0);
        run_line(8'h00, 0, "R6");

        done = 1;
        report();
        $finish;
    end

endmodule